// File: doc/BRIEF.md
# Counting Semaphore Cell

This block holds one 16-bit counting semaphore that several hardware threads share through a single request port. A thread takes a unit with a P access and returns a unit with a V access. Each operation comes in a waiting form and a non-waiting form. A waiting P that finds the count at zero is parked: the cell records the requester in a per-thread wait mask and answers with a stall flag. The next V releases every parked thread at once by pulsing its wake line. The woken thread then issues its P access again.

Each request is answered one cycle later with a response strobe, read data and a stall flag. A peek reads the raw count, and a poke is accepted but has no effect. A mode input marks the cell as a queue-type cell. In that mode the semaphore operations are inert, so one cell slot can sit behind a shared decoder.

Top module: `csem_cell`

## Requirements
- R1: While reset is held and after it is released, the count is 0, no requester is parked, `wake_o` is all zero, and `rsp_valid_o` and `rsp_stall_o` are low.
- R2: Operation codes on `req_op_i` are 0 peek, 1 poke, 2 waiting P, 3 non-waiting P, 4 waiting V, 5 non-waiting V. Each request with `req_valid_i` high is answered by `rsp_valid_o` high in the following cycle, with its data and stall flag.
- R3: A P of either form with a nonzero count returns the count from before the access, zero-extended, and decrements the count by one without a stall.
- R4: A waiting P at count zero returns 0, raises `rsp_stall_o`, sets the requester's bit in the wait mask and leaves the count at zero.
- R5: A non-waiting P at count zero returns 0 without a stall and changes neither the count nor the wait mask.
- R6: A V of either form increments the count, except at 0xFFFF, where the count stays at 0xFFFF. The V write data has no effect.
- R7: Every V drives the whole wait mask onto `wake_o` for exactly one cycle, the cycle after the V, and empties the mask. A V with no parked requester leaves `wake_o` at zero.
- R8: A peek returns the current count and leaves it unchanged. A poke changes neither the count nor the wait mask, whatever its data.
- R9: With `fifo_mode_i` high, P accesses of either form return 0 with no stall and no count change, and V accesses neither change the count nor wake anyone.
- R10: A requester that was parked and woken by a V gets the unit when it issues its P again: the retried P returns the pre-decrement count and does not stall.
- R11: Codes 6 and 7 are answered with data 0 and no stall, and change neither the count nor the wait mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| fifo_mode_i | input | 1 | Marks the cell as queue type; semaphore operations become inert |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation code |
| req_id_i | input | ID_W (2) | Requesting thread |
| req_wdata_i | input | DATA_W (32) | Write data (unused by the semaphore) |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_data_o | output | DATA_W (32) | Read data |
| rsp_stall_o | output | 1 | Requester was parked |
| wake_o | output | NUM_REQ (4) | One-cycle wake pulse per parked thread |

## Verification
The wake pulse from a V and the response to the next access can appear in the same cycle. A woken thread that retries immediately sees its wake and its retried P handled back to back. The bench parks two threads, issues a V, and sends the retried P in the very next cycle. It checks that `wake_o` carries exactly the parked set in the cycle after the V and returns to zero in the cycle after that. It also checks that the retried P sees the incremented count and does not stall, and that a thread parked right after the release is the only bit left in the mask at the following V.

// File: rtl/csem_pkg.sv
package csem_pkg;

   typedef enum logic [2:0] {
      OP_PEEK      = 3'd0,
      OP_POKE      = 3'd1,
      OP_TAKE_WAIT = 3'd2,
      OP_TAKE_TRY  = 3'd3,
      OP_GIVE_WAIT = 3'd4,
      OP_GIVE_TRY  = 3'd5
   } sem_op_e;

   typedef struct packed {
      logic peek;
      logic take;
      logic take_wait;
      logic give;
   } sem_dec_t;

endpackage

// File: rtl/csem_decode.sv
module csem_decode
   import csem_pkg::*;
(
   input  logic       valid_i,
   input  logic [2:0] op_i,
   input  logic       fifo_mode_i,
   output sem_dec_t   dec_o
);

   logic is_take;
   logic is_give;

   always_comb begin
      is_take = (op_i == OP_TAKE_WAIT) || (op_i == OP_TAKE_TRY);
      is_give = (op_i == OP_GIVE_WAIT) || (op_i == OP_GIVE_TRY);
      dec_o.peek      = valid_i && (op_i == OP_PEEK);
      dec_o.take      = valid_i && is_take && !fifo_mode_i;
      dec_o.take_wait = (op_i == OP_TAKE_WAIT);
      dec_o.give      = valid_i && is_give && !fifo_mode_i;
   end

endmodule

// File: rtl/csem_counter.sv
module csem_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             take_i,
   input  logic             give_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
      end else if (give_i) begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      end else if (take_i) begin
         if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/csem_waitset.sv
module csem_waitset #(
   parameter int NUM_REQ = 4,
   parameter int ID_W    = 2
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               park_i,
   input  logic [ID_W-1:0]    park_id_i,
   input  logic               release_i,
   output logic [NUM_REQ-1:0] blk_o,
   output logic [NUM_REQ-1:0] wake_o
);

   logic [NUM_REQ-1:0] blk_q;
   logic [NUM_REQ-1:0] wake_q;

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (!rst_n_i) begin
            blk_q[i]  <= 1'b0;
            wake_q[i] <= 1'b0;
         end else begin
            wake_q[i] <= release_i && blk_q[i];
            if (release_i)
               blk_q[i] <= 1'b0;
            else if (park_i && (park_id_i == ID_W'(i)))
               blk_q[i] <= 1'b1;
         end
      end
   end

   assign blk_o  = blk_q;
   assign wake_o = wake_q;

endmodule

// File: rtl/csem_cell.sv
module csem_cell
   import csem_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 32,
   parameter int NUM_REQ = 4,
   parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               fifo_mode_i,
   input  logic               req_valid_i,
   input  logic [2:0]         req_op_i,
   input  logic [ID_W-1:0]    req_id_i,
   input  logic [DATA_W-1:0]  req_wdata_i,
   output logic               rsp_valid_o,
   output logic [DATA_W-1:0]  rsp_data_o,
   output logic               rsp_stall_o,
   output logic [NUM_REQ-1:0] wake_o
);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("csem_cell: CNT_W must be between 1 and DATA_W");
   end
   if (NUM_REQ < 1) begin : g_bad_num_req
      $error("csem_cell: NUM_REQ must be at least 1");
   end
   if ((1 << ID_W) < NUM_REQ) begin : g_bad_id_w
      $error("csem_cell: ID_W too narrow for NUM_REQ");
   end

   sem_dec_t           dec;
   logic [CNT_W-1:0]   cnt_q;
   logic               cnt_zero;
   logic               park;
   logic [NUM_REQ-1:0] blk_q;
   logic               rsp_valid_q;
   logic               rsp_stall_q;
   logic [DATA_W-1:0]  rsp_data_q;
   logic               unused_wdata;

   assign unused_wdata = ^req_wdata_i;

   csem_decode u_dec (
      .valid_i     (req_valid_i),
      .op_i        (req_op_i),
      .fifo_mode_i (fifo_mode_i),
      .dec_o       (dec)
   );

   csem_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .take_i  (dec.take),
      .give_i  (dec.give),
      .cnt_o   (cnt_q),
      .zero_o  (cnt_zero)
   );

   assign park = dec.take && dec.take_wait && cnt_zero;

   csem_waitset #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_wait (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .park_i    (park),
      .park_id_i (req_id_i),
      .release_i (dec.give),
      .blk_o     (blk_q),
      .wake_o    (wake_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         rsp_valid_q <= 1'b0;
         rsp_stall_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= req_valid_i;
         rsp_stall_q <= park;
         rsp_data_q  <= (dec.peek || dec.take) ? DATA_W'(cnt_q) : '0;
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_stall_o = rsp_stall_q;
   assign rsp_data_o  = rsp_data_q;

endmodule

// File: rtl/csem_cell_chk.sv
module csem_cell_chk #(
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 32,
   parameter int NUM_REQ = 4,
   parameter int ID_W    = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fifo_mode,
   input logic               req_valid,
   input logic [2:0]         req_op,
   input logic [ID_W-1:0]    req_id,
   input logic [CNT_W-1:0]   cnt,
   input logic [NUM_REQ-1:0] blk,
   input logic [NUM_REQ-1:0] wake,
   input logic               rsp_valid,
   input logic [DATA_W-1:0]  rsp_data,
   input logic               rsp_stall
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

   logic is_take, is_give, sem;
   assign is_take = req_valid && (req_op == 3'd2 || req_op == 3'd3);
   assign is_give = req_valid && (req_op == 3'd4 || req_op == 3'd5);
   assign sem     = !fifo_mode;

   // R2
   response_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R3
   take_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_take && sem && cnt != '0) |=>
         (cnt == $past(cnt) - CONE) && (rsp_data == DATA_W'($past(cnt))) && !rsp_stall);

   // R4
   park_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd2 && sem && cnt == '0 && 32'(req_id) < NUM_REQ) |=>
         rsp_stall && blk[$past(req_id)] && cnt == '0);

   // R5
   try_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd3 && sem && cnt == '0) |=>
         !rsp_stall && rsp_data == '0 && $stable(cnt) && $stable(blk));

   // R6
   give_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_give && sem && cnt == CMAX) |=> cnt == CMAX);

   // R7
   give_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_give && sem) |=> blk == '0 && wake == $past(blk));

   // R7
   wake_only_after_give_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake != '0) |-> $past(is_give && sem));

   // R8
   poke_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd1) |=> $stable(cnt) && $stable(blk));

   // R9
   fifo_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && (is_take || is_give)) |=>
         $stable(cnt) && rsp_data == '0 && !rsp_stall && wake == '0);

   // R2
   stall_in_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_stall |-> rsp_valid);

endmodule

bind csem_cell csem_cell_chk #(
   .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_REQ(NUM_REQ), .ID_W(ID_W)
) u_chk (
   .clk       (clk_i),
   .rst_n     (rst_n_i),
   .fifo_mode (fifo_mode_i),
   .req_valid (req_valid_i),
   .req_op    (req_op_i),
   .req_id    (req_id_i),
   .cnt       (cnt_q),
   .blk       (blk_q),
   .wake      (wake_o),
   .rsp_valid (rsp_valid_o),
   .rsp_data  (rsp_data_o),
   .rsp_stall (rsp_stall_o)
);

// File: tb/csem_cell_test.sv
`timescale 1ns/1ps
module csem_cell_test;

   localparam int NREQ = 4;
   localparam int IDW  = 2;
   localparam int DW   = 32;

   localparam logic [2:0] C_PEEK  = 3'd0;
   localparam logic [2:0] C_POKE  = 3'd1;
   localparam logic [2:0] C_PWAIT = 3'd2;
   localparam logic [2:0] C_PTRY  = 3'd3;
   localparam logic [2:0] C_VWAIT = 3'd4;
   localparam logic [2:0] C_VTRY  = 3'd5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fifo_mode = 1'b0;
   logic            req_valid = 1'b0;
   logic [2:0]      req_op = '0;
   logic [IDW-1:0]  req_id = '0;
   logic [DW-1:0]   req_wdata = '0;
   logic            rsp_valid;
   logic [DW-1:0]   rsp_data;
   logic            rsp_stall;
   logic [NREQ-1:0] wake;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic            s_valid;
   logic [DW-1:0]   s_data;
   logic            s_stall;
   logic [NREQ-1:0] s_wake;

   always #2 clk = ~clk;

   csem_cell #(.CNT_W(16), .DATA_W(DW), .NUM_REQ(NREQ)) uut (
      .clk_i       (clk),
      .rst_n_i     (rst_n),
      .fifo_mode_i (fifo_mode),
      .req_valid_i (req_valid),
      .req_op_i    (req_op),
      .req_id_i    (req_id),
      .req_wdata_i (req_wdata),
      .rsp_valid_o (rsp_valid),
      .rsp_data_o  (rsp_data),
      .rsp_stall_o (rsp_stall),
      .wake_o      (wake)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge with the response captured
   task automatic issue(input logic [2:0] op, input int id, input logic [31:0] wd);
      req_valid = 1'b1;
      req_op    = op;
      req_id    = IDW'(id);
      req_wdata = wd;
      @(negedge clk);
      s_valid = rsp_valid;
      s_data  = rsp_data;
      s_stall = rsp_stall;
      s_wake  = wake;
      req_valid = 1'b0;
      req_wdata = '0;
   endtask

   task automatic peek_chk(input string rq, input logic [31:0] exp);
      issue(C_PEEK, 0, 0);
      chk(rq, s_data, exp);
   endtask

   initial begin
      #(4 * 190000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: held reset
      chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
      chk("R1 wake in reset", 32'(wake), 0);
      chk("R1 stall in reset", 32'(rsp_stall), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
      peek_chk("R1 count after reset", 0);
      chk("R2 response strobe", 32'(s_valid), 1);

      // R5: non-waiting P at zero
      issue(C_PTRY, 1, 0);
      chk("R5 try data", s_data, 0);
      chk("R5 try stall", 32'(s_stall), 0);
      issue(C_VTRY, 3, 0);
      chk("R5 no one parked by try", 32'(s_wake), 0);
      issue(C_PTRY, 0, 0);   // back to zero
      chk("R3 take after give", s_data, 1);

      // R4: park two threads
      issue(C_PWAIT, 0, 0);
      chk("R4 stall id0", 32'(s_stall), 1);
      chk("R4 data id0", s_data, 0);
      issue(C_PWAIT, 2, 0);
      chk("R4 stall id2", 32'(s_stall), 1);
      peek_chk("R4 count stays zero", 0);

      // R7 + R10: V releases both, retry in the very next cycle
      issue(C_VWAIT, 1, 32'hDEAD_BEEF);
      chk("R7 wake pulse set", 32'(s_wake), 32'b0101);
      issue(C_PWAIT, 0, 0);
      chk("R10 retried P data", s_data, 1);
      chk("R10 retried P stall", 32'(s_stall), 0);
      chk("R7 wake lasts one cycle", 32'(s_wake), 0);
      issue(C_PWAIT, 2, 0);
      chk("R4 re-park id2", 32'(s_stall), 1);
      issue(C_VTRY, 3, 0);
      chk("R7 only id2 parked", 32'(s_wake), 32'b0100);
      issue(C_PTRY, 2, 0);
      chk("R10 id2 retry", s_data, 1);
      issue(C_VWAIT, 1, 0);
      chk("R7 no wake when none parked", 32'(s_wake), 0);
      issue(C_PTRY, 1, 0);
      chk("R3 drain", s_data, 1);

      // R3/R6: sweep counts 1..20 with both forms
      for (int n = 1; n <= 20; n++) begin
         for (int k = 0; k < n; k++)
            issue((k % 2) ? C_VTRY : C_VWAIT, k % NREQ, 32'hA5A5_0000 + k);
         peek_chk("R6 count after gives", 32'(n));
         for (int k = 0; k < n; k++) begin
            issue((k % 2) ? C_PTRY : C_PWAIT, k % NREQ, 0);
            chk("R3 take returns prior count", s_data, 32'(n - k));
            chk("R3 take no stall", 32'(s_stall), 0);
         end
         peek_chk("R3 count drained", 0);
      end

      // R8: poke ignored
      issue(C_VTRY, 0, 0);
      issue(C_POKE, 0, 32'h0000_1234);
      chk("R8 poke data", s_data, 0);
      peek_chk("R8 count after poke", 1);
      peek_chk("R8 peek leaves count", 1);

      // R11: reserved codes
      issue(3'd6, 0, 32'hFFFF);
      chk("R11 code6 data", s_data, 0);
      issue(3'd7, 0, 32'hFFFF);
      chk("R11 code7 data", s_data, 0);
      chk("R11 code7 stall", 32'(s_stall), 0);
      peek_chk("R11 count unchanged", 1);
      issue(C_PTRY, 0, 0);

      // R9: queue-type mode
      issue(C_PWAIT, 1, 0);          // park id1 at zero
      fifo_mode = 1'b1;
      issue(C_VWAIT, 0, 0);
      chk("R9 give no wake", 32'(s_wake), 0);
      issue(C_PWAIT, 3, 0);
      chk("R9 take at zero no stall", 32'(s_stall), 0);
      fifo_mode = 1'b0;
      peek_chk("R9 give ignored", 0);
      issue(C_VTRY, 0, 0);
      chk("R9 id1 still parked", 32'(s_wake), 32'b0010);
      issue(C_VTRY, 0, 0);
      issue(C_VTRY, 0, 0);
      fifo_mode = 1'b1;
      issue(C_PWAIT, 2, 0);
      chk("R9 take data", s_data, 0);
      issue(C_PTRY, 2, 0);
      chk("R9 try data", s_data, 0);
      fifo_mode = 1'b0;
      peek_chk("R9 count kept", 3);

      // R6: saturation
      for (int k = 0; k < 65532; k++) issue(C_VTRY, k % NREQ, 32'(k));
      peek_chk("R6 reach max", 32'hFFFF);
      issue(C_VWAIT, 0, 0);
      peek_chk("R6 saturate", 32'hFFFF);
      issue(C_PTRY, 0, 0);
      chk("R3 take at max", s_data, 32'hFFFF);
      peek_chk("R3 after take at max", 32'hFFFE);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule